// File: doc/BRIEF.md
# Predicated Integer Execution Unit with Pre-Shifted Operand

This block is the integer execution stage of a 32-bit datapath. Each cycle it takes two operands, an operation code, a shift request for the second operand, a set-flags bit, a 4-bit condition selector and the current N, Z, C and V flags. The second operand first goes through a barrel shifter in the same cycle. The shifter offers logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. The shifted value then feeds an operation unit. That unit offers bitwise logic, add, subtract, reverse subtract, bit clear, and four compare-style operations that only produce flags.

Every operation is predicated. The condition selector is tested against the incoming flags. When it fails, nothing is written and the flags pass through unchanged. The outputs are a result, a write-enable and the updated flags. All of them are registered and appear one clock after the inputs. Register storage, multiply and memory access are outside the block.

Top module: `cond_exec_unit`

## Requirements
- R1: While reset is asserted, `result` is 0, `wr_en` is 0 and all four output flags are 0.
- R2: Shift type encodings are 000 logical left, 001 logical right, 010 arithmetic right, 011 rotate right, and 100 rotate right by one through C, which ignores the amount and puts the incoming C into bit 31 and bit 0 into the carry-out. For shift types 000 to 011, an amount of 0 passes the operand through unchanged, and the shifter carry-out equals the incoming C. Codes 101 to 111 behave like amount 0.
- R3: For amounts of 32 and above, the shifter behaves as follows. A logical shift of exactly 32 gives 0 with carry-out equal to the last bit shifted out (bit 0 for left, bit 31 for right). A logical shift beyond 32 gives 0 with carry-out 0. An arithmetic right shift gives 32 copies of bit 31 with carry-out equal to bit 31. A rotate uses the amount modulo 32, and its carry-out is bit 31 of the rotated value.
- R4: Opcode encodings for the logical group are 0 AND, 1 XOR, 9 OR, 10 move (the shifted operand), 12 move-inverted, and 11 bit clear (first AND NOT shifted second).
- R5: Opcode encodings for the arithmetic group are 4 add, 2 subtract (first minus shifted second) and 3 reverse subtract (shifted second minus first). C is the adder carry, which means "no borrow" for subtraction. V is signed overflow.
- R6: Opcodes 5 test (AND), 6 test-equivalence (XOR), 7 compare (subtract) and 8 compare-negative (add) never raise `wr_en`. When their condition passes, they update the flags even if set-flags is 0.
- R7: For logical operations that update the flags, N is bit 31 of the result and Z is set when the result is zero. C takes the shifter carry-out and V keeps its incoming value. Test-equivalence keeps both the incoming C and the incoming V.
- R8: A writing operation with set-flags 0 outputs the incoming flags unchanged.
- R9: Condition codes are 0 EQ (Z), 1 NE, 2 CS (C), 3 CC, 4 MI (N), 5 PL, 6 VS (V), 7 VC, 8 HI (C and not Z), 9 LS, 10 GE (N=V), 11 LT, 12 GT (not Z and N=V), 13 LE, 14 always, 15 never. When the condition fails, `wr_en` is 0, `result` holds its previous value and the output flags equal the incoming flags.
- R10: All outputs change only at the clock edge after the inputs are applied (one cycle latency).
- R11: Opcodes 13 to 15 are reserved. They never write, and they output the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, before shifting |
| shift_type | input | 3 | Shifter mode (R2) |
| shift_amt | input | 8 | Shift amount |
| opcode | input | 4 | Operation code (R4, R5, R6, R11) |
| set_flags | input | 1 | Request a flag update for writing operations |
| cond | input | 4 | Condition selector (R9) |
| flag_n | input | 1 | Incoming negative flag |
| flag_z | input | 1 | Incoming zero flag |
| flag_c | input | 1 | Incoming carry flag |
| flag_v | input | 1 | Incoming overflow flag |
| result | output | 32 | Registered result; holds when nothing is written |
| wr_en | output | 1 | Registered write-enable |
| out_n | output | 1 | Updated negative flag |
| out_z | output | 1 | Updated zero flag |
| out_c | output | 1 | Updated carry flag |
| out_v | output | 1 | Updated overflow flag |

## Verification
Condition evaluation and the flag update can both act in the same cycle. An operation with set-flags high, or a compare, whose condition fails must suppress both the write and the flag change. The bench provokes this by sweeping all 16 condition codes against all 16 incoming flag combinations. Writing moves and flag-setting compares are swept this way. Each cycle is judged on whether `wr_en`, the held `result` and the flags match a condition table computed in the bench.

The shifter carry-out and the flag update also meet in the same cycle. Logical operations with amount 0, rotate-through-carry and out-of-range amounts are checked for the carry each one should deliver.

// File: rtl/cx_pkg.sv
package cx_pkg;

    // shifter modes
    localparam logic [2:0] SH_LSL = 3'd0;
    localparam logic [2:0] SH_LSR = 3'd1;
    localparam logic [2:0] SH_ASR = 3'd2;
    localparam logic [2:0] SH_ROR = 3'd3;
    localparam logic [2:0] SH_RRX = 3'd4;

    // operation codes
    localparam logic [3:0] OP_AND = 4'd0;
    localparam logic [3:0] OP_XOR = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_RSB = 4'd3;
    localparam logic [3:0] OP_ADD = 4'd4;
    localparam logic [3:0] OP_TST = 4'd5;
    localparam logic [3:0] OP_TEQ = 4'd6;
    localparam logic [3:0] OP_CMP = 4'd7;
    localparam logic [3:0] OP_CMN = 4'd8;
    localparam logic [3:0] OP_ORR = 4'd9;
    localparam logic [3:0] OP_MOV = 4'd10;
    localparam logic [3:0] OP_BIC = 4'd11;
    localparam logic [3:0] OP_MVN = 4'd12;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/cx_shifter.sv
module cx_shifter
    import cx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = 8
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [2:0]        sh_type,
    input  logic [AMT_W-1:0]  amt,
    input  logic              c_in,
    output logic [DATA_W-1:0] shifted,
    output logic              c_out
);
    // DATA_W is a power of two so the rotate index wraps naturally
    localparam int unsigned RW = $clog2(DATA_W);

    logic [DATA_W:0]          lsl_t;
    logic [DATA_W:0]          lsr_t;
    logic signed [DATA_W:0]   asr_t;
    logic [2*DATA_W-1:0]      ror_t;
    logic [RW-1:0]            rot;

    always_comb begin
        rot   = amt[RW-1:0];
        lsl_t = {1'b0, opnd} << amt;
        lsr_t = {opnd, 1'b0} >> amt;
        asr_t = $signed({opnd, 1'b0}) >>> amt;
        ror_t = {opnd, opnd} >> rot;

        shifted = opnd;
        c_out   = c_in;
        if (sh_type == SH_RRX) begin
            shifted = {c_in, opnd[DATA_W-1:1]};
            c_out   = opnd[0];
        end else if (amt != '0) begin
            case (sh_type)
                SH_LSL: begin
                    shifted = lsl_t[DATA_W-1:0];
                    c_out   = lsl_t[DATA_W];
                end
                SH_LSR: begin
                    shifted = lsr_t[DATA_W:1];
                    c_out   = lsr_t[0];
                end
                SH_ASR: begin
                    shifted = asr_t[DATA_W:1];
                    c_out   = asr_t[0];
                end
                SH_ROR: begin
                    shifted = ror_t[DATA_W-1:0];
                    c_out   = ror_t[DATA_W-1];
                end
                default: begin
                    shifted = opnd;
                    c_out   = c_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/cx_cond.sv
module cx_cond
    import cx_pkg::*;
(
    input  logic [3:0] cond,
    input  flags_t     fl,
    output logic       pass
);
    logic base;

    // even codes test a predicate, odd codes its inverse (except 14/15)
    always_comb begin
        case (cond[3:1])
            3'd0:    base = fl.z;
            3'd1:    base = fl.c;
            3'd2:    base = fl.n;
            3'd3:    base = fl.v;
            3'd4:    base = fl.c & ~fl.z;
            3'd5:    base = (fl.n == fl.v);
            3'd6:    base = ~fl.z & (fl.n == fl.v);
            default: base = 1'b1;
        endcase
        if (cond[3:1] == 3'd7) pass = ~cond[0];
        else                   pass = base ^ cond[0];
    end

endmodule

// File: rtl/cx_alu.sv
module cx_alu
    import cx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        op,
    input  logic              sh_c,
    input  flags_t            fl_in,
    output logic [DATA_W-1:0] res,
    output flags_t            fl_new,
    output logic              writes,
    output logic              test_only,
    output logic              known
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] add_x, add_y, logic_r;
    logic [DATA_W:0]   sum;
    logic              add_ci, arith;

    always_comb begin
        add_x     = '0;
        add_y     = '0;
        add_ci    = 1'b0;
        arith     = 1'b0;
        logic_r   = '0;
        writes    = 1'b1;
        test_only = 1'b0;
        known     = 1'b1;
        case (op)
            OP_AND: logic_r = a & b;
            OP_XOR: logic_r = a ^ b;
            OP_ORR: logic_r = a | b;
            OP_MOV: logic_r = b;
            OP_MVN: logic_r = ~b;
            OP_BIC: logic_r = a & ~b;
            OP_TST: begin logic_r = a & b; writes = 1'b0; test_only = 1'b1; end
            OP_TEQ: begin logic_r = a ^ b; writes = 1'b0; test_only = 1'b1; end
            OP_ADD: begin arith = 1'b1; add_x = a; add_y = b; end
            OP_CMN: begin
                arith = 1'b1; add_x = a; add_y = b;
                writes = 1'b0; test_only = 1'b1;
            end
            OP_SUB: begin arith = 1'b1; add_x = a; add_y = ~b; add_ci = 1'b1; end
            OP_CMP: begin
                arith = 1'b1; add_x = a; add_y = ~b; add_ci = 1'b1;
                writes = 1'b0; test_only = 1'b1;
            end
            OP_RSB: begin arith = 1'b1; add_x = b; add_y = ~a; add_ci = 1'b1; end
            default: begin known = 1'b0; writes = 1'b0; end
        endcase

        sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_ci};
        res = arith ? sum[MSB:0] : logic_r;

        fl_new.n = res[MSB];
        fl_new.z = (res == '0);
        if (arith) begin
            fl_new.c = sum[DATA_W];
            fl_new.v = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);
        end else begin
            fl_new.c = (op == OP_TEQ) ? fl_in.c : sh_c;
            fl_new.v = fl_in.v;
        end
    end

endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import cx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        shift_type,
    input  logic [AMT_W-1:0]  shift_amt,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic [3:0]        cond,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_v,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              out_n,
    output logic              out_z,
    output logic              out_c,
    output logic              out_v
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr;
        flags_t            flags;
    } state_t;

    state_t            st_d, st_q;
    flags_t            fl_in, alu_fl;
    logic [DATA_W-1:0] sh_val, alu_res;
    logic              sh_c, cond_ok, alu_wr, alu_test, alu_known;
    logic              exec, upd;

    assign fl_in = {flag_n, flag_z, flag_c, flag_v};

    cx_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
        .opnd    (op_b),
        .sh_type (shift_type),
        .amt     (shift_amt),
        .c_in    (flag_c),
        .shifted (sh_val),
        .c_out   (sh_c)
    );

    cx_cond u_cond (
        .cond (cond),
        .fl   (fl_in),
        .pass (cond_ok)
    );

    cx_alu #(.DATA_W(DATA_W)) u_alu (
        .a         (op_a),
        .b         (sh_val),
        .op        (opcode),
        .sh_c      (sh_c),
        .fl_in     (fl_in),
        .res       (alu_res),
        .fl_new    (alu_fl),
        .writes    (alu_wr),
        .test_only (alu_test),
        .known     (alu_known)
    );

    always_comb begin
        exec     = cond_ok && alu_known;
        upd      = exec && (alu_test || set_flags);
        st_d     = st_q;
        st_d.wr  = exec && alu_wr;
        if (exec && alu_wr) st_d.result = alu_res;
        st_d.flags = upd ? alu_fl : fl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.result;
    assign wr_en  = st_q.wr;
    assign out_n  = st_q.flags.n;
    assign out_z  = st_q.flags.z;
    assign out_c  = st_q.flags.c;
    assign out_v  = st_q.flags.v;

endmodule

// File: rtl/cx_checker.sv
module cx_checker
    import cx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        opcode,
    input logic              set_flags,
    input logic [3:0]        cond,
    input logic [3:0]        flags_in,
    input logic [3:0]        flags_out,
    input logic              wr_en,
    input logic [DATA_W-1:0] result
);
    logic is_test;
    assign is_test = (opcode >= OP_TST) && (opcode <= OP_CMN);

    assert_never_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'hF) |=> (!wr_en && $stable(result)));

    assert_never_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'hF) |=> (flags_out == $past(flags_in)));

    assert_test_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> !wr_en);

    assert_teq_keeps_cv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_TEQ) |=> (flags_out[1:0] == $past(flags_in[1:0])));

    assert_no_set_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags && !is_test) |=> (flags_out == $past(flags_in)));

    assert_reserved_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode > OP_MVN) |=> (!wr_en && flags_out == $past(flags_in) && $stable(result)));

endmodule

bind cond_exec_unit cx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .set_flags (set_flags),
    .cond      (cond),
    .flags_in  ({flag_n, flag_z, flag_c, flag_v}),
    .flags_out ({out_n, out_z, out_c, out_v}),
    .wr_en     (wr_en),
    .result    (result)
);

// File: tb/tb_cond_exec_unit.sv
module tb_cond_exec_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [2:0]  shift_type = '0;
    logic [7:0]  shift_amt = '0;
    logic [3:0]  opcode = 4'd10;
    logic        set_flags = 1'b0;
    logic [3:0]  cond = 4'hF;
    logic        flag_n = 0, flag_z = 0, flag_c = 0, flag_v = 0;
    logic [31:0] result;
    logic        wr_en, out_n, out_z, out_c, out_v;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        logic [3:0]  fl;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [31:0] exp_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .shift_type(shift_type), .shift_amt(shift_amt), .opcode(opcode),
        .set_flags(set_flags), .cond(cond),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .result(result), .wr_en(wr_en),
        .out_n(out_n), .out_z(out_z), .out_c(out_c), .out_v(out_v)
    );

    // bit-serial shifter model: {carry, value}
    function automatic logic [32:0] mdl_shift(logic [31:0] b, logic [2:0] t,
                                              logic [7:0] amt, logic cin);
        logic [31:0] r = b;
        logic        co = cin;
        if (t == 3'd4) begin
            co = b[0];
            r  = {cin, b[31:1]};
        end else if (t <= 3'd3) begin
            for (int i = 0; i < int'(amt); i++) begin
                case (t)
                    3'd0: begin co = r[31]; r = {r[30:0], 1'b0}; end
                    3'd1: begin co = r[0];  r = {1'b0, r[31:1]}; end
                    3'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
                    default: begin co = r[0]; r = {r[0], r[31:1]}; end
                endcase
            end
        end
        return {co, r};
    endfunction

    function automatic logic mdl_cond(logic [3:0] c, logic n, logic z, logic cf, logic v);
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cf;
            4'd3:  return !cf;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cf && !z;
            4'd9:  return !cf || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic [2:0] st, input logic [7:0] amt,
                          input logic [3:0] op, input logic s, input logic [3:0] c,
                          input logic [3:0] fl, input string tag);
        logic [32:0] shr;
        logic [31:0] sb, r;
        logic        sc, ok, known, wr, test, nc, nv;
        logic [32:0] s33;
        item_t       it;
        @(negedge clk);
        op_a = a; op_b = b; shift_type = st; shift_amt = amt; opcode = op;
        set_flags = s; cond = c;
        {flag_n, flag_z, flag_c, flag_v} = fl;

        shr = mdl_shift(b, st, amt, fl[1]);
        sc = shr[32]; sb = shr[31:0];
        ok = mdl_cond(c, fl[3], fl[2], fl[1], fl[0]);
        known = (op <= 4'd12);
        wr = known && !(op >= 4'd5 && op <= 4'd8);
        test = (op >= 4'd5 && op <= 4'd8);
        r = '0; nc = sc; nv = fl[0];
        case (op)
            4'd0, 4'd5: r = a & sb;
            4'd1: r = a ^ sb;
            4'd6: begin r = a ^ sb; nc = fl[1]; end
            4'd9: r = a | sb;
            4'd10: r = sb;
            4'd11: r = a & ~sb;
            4'd12: r = ~sb;
            4'd4, 4'd8: begin
                s33 = {1'b0, a} + {1'b0, sb};
                r = s33[31:0]; nc = s33[32];
                nv = (a[31] == sb[31]) && (r[31] != a[31]);
            end
            4'd2, 4'd7: begin
                r = a - sb; nc = (a >= sb);
                nv = (a[31] != sb[31]) && (r[31] != a[31]);
            end
            4'd3: begin
                r = sb - a; nc = (sb >= a);
                nv = (sb[31] != a[31]) && (r[31] != sb[31]);
            end
            default: r = '0;
        endcase

        it.tag = tag;
        it.fl  = fl;
        it.wr  = 1'b0;
        if (ok && known) begin
            it.wr = wr;
            if (wr) exp_res = r;
            if (test || s) it.fl = {r[31], (r == 32'd0), nc, nv};
        end
        it.res = exp_res;
        sb_q.push_back(it);
    endtask

    // monitor: outputs for an item pushed at a falling edge are valid after the next rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res || wr_en !== e.wr ||
                {out_n, out_z, out_c, out_v} !== e.fl) begin
                errors++;
                $display("FAIL %s: result %h exp %h, wr_en %b exp %b, nzcv %b exp %b",
                         e.tag, result, e.res, wr_en, e.wr,
                         {out_n, out_z, out_c, out_v}, e.fl);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (result !== 32'd0 || wr_en !== 1'b0 || {out_n, out_z, out_c, out_v} !== 4'b0) begin
            errors++;
            $display("FAIL R1: result %h wr %b nzcv %b exp 0 0 0000",
                     result, wr_en, {out_n, out_z, out_c, out_v});
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: new inputs do not reach outputs before the next rising edge
        run_op(32'h0, 32'hCAFE_F00D, 3'd0, 8'd0, 4'd10, 1'b0, 4'd14, 4'b0000, "R10");
        #1;
        checks++;
        if (result !== 32'd0 || wr_en !== 1'b0) begin
            errors++;
            $display("FAIL R10: result %h wr %b exp 00000000 0 before edge", result, wr_en);
        end

        // R2: shifter modes and amount zero
        run_op(32'h0, 32'h0000_000F, 3'd0, 8'd4,  4'd10, 1'b1, 4'd14, 4'b0011, "R2");
        run_op(32'h0, 32'h8000_0001, 3'd0, 8'd1,  4'd10, 1'b1, 4'd14, 4'b0000, "R2");
        run_op(32'h0, 32'h1234_5678, 3'd3, 8'd8,  4'd10, 1'b1, 4'd14, 4'b0010, "R2");
        run_op(32'h0, 32'h0000_0003, 3'd4, 8'd9,  4'd10, 1'b1, 4'd14, 4'b0010, "R2");
        run_op(32'h0, 32'h0000_0003, 3'd4, 8'd0,  4'd10, 1'b1, 4'd14, 4'b0000, "R2");
        run_op(32'h0, 32'h8000_0000, 3'd1, 8'd0,  4'd10, 1'b1, 4'd14, 4'b0010, "R2");
        run_op(32'h0, 32'hF000_0000, 3'd2, 8'd4,  4'd10, 1'b1, 4'd14, 4'b0000, "R2");
        run_op(32'h0, 32'h0000_00F0, 3'd6, 8'd4,  4'd10, 1'b1, 4'd14, 4'b0010, "R2");
        // R3: large amounts
        run_op(32'h0, 32'h8000_0000, 3'd1, 8'd32, 4'd10, 1'b1, 4'd14, 4'b0000, "R3");
        run_op(32'h0, 32'h0000_0001, 3'd0, 8'd32, 4'd10, 1'b1, 4'd14, 4'b0000, "R3");
        run_op(32'h0, 32'hFFFF_FFFF, 3'd0, 8'd33, 4'd10, 1'b1, 4'd14, 4'b0010, "R3");
        run_op(32'h0, 32'h8000_0000, 3'd2, 8'd40, 4'd10, 1'b1, 4'd14, 4'b0000, "R3");
        run_op(32'h0, 32'h9234_5678, 3'd3, 8'd32, 4'd10, 1'b1, 4'd14, 4'b0000, "R3");
        run_op(32'h0, 32'h1234_5678, 3'd3, 8'd36, 4'd10, 1'b1, 4'd14, 4'b0000, "R3");
        // R4: logical group
        run_op(32'hFF00_FF00, 32'h0FF0_0FF0, 3'd0, 8'd0, 4'd0,  1'b1, 4'd14, 4'b0001, "R4");
        run_op(32'hFF00_FF00, 32'h0FF0_0FF0, 3'd0, 8'd0, 4'd1,  1'b1, 4'd14, 4'b0000, "R4");
        run_op(32'hFF00_FF00, 32'h0FF0_0FF0, 3'd0, 8'd0, 4'd9,  1'b1, 4'd14, 4'b0000, "R4");
        run_op(32'h0000_00FF, 32'h0000_000F, 3'd0, 8'd0, 4'd11, 1'b1, 4'd14, 4'b0000, "R4");
        run_op(32'h0,         32'hFFFF_FFFF, 3'd0, 8'd0, 4'd12, 1'b1, 4'd14, 4'b0000, "R4");
        // R5: arithmetic group
        run_op(32'h7FFF_FFFF, 32'h0000_0001, 3'd0, 8'd0, 4'd4, 1'b1, 4'd14, 4'b0000, "R5");
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 3'd0, 8'd0, 4'd4, 1'b1, 4'd14, 4'b0000, "R5");
        run_op(32'h0000_0005, 32'h0000_0005, 3'd0, 8'd0, 4'd2, 1'b1, 4'd14, 4'b0000, "R5");
        run_op(32'h0000_0003, 32'h0000_0005, 3'd0, 8'd0, 4'd2, 1'b1, 4'd14, 4'b0000, "R5");
        run_op(32'h8000_0000, 32'h0000_0001, 3'd0, 8'd0, 4'd2, 1'b1, 4'd14, 4'b0000, "R5");
        run_op(32'h0000_0000, 32'h0000_0007, 3'd0, 8'd0, 4'd3, 1'b1, 4'd14, 4'b0000, "R5");
        run_op(32'h0000_0001, 32'h0000_0001, 3'd0, 8'd6, 4'd4, 1'b0, 4'd14, 4'b0000, "R5");
        run_op(32'h0000_0001, 32'h0000_0001, 3'd0, 8'd6, 4'd3, 1'b0, 4'd14, 4'b0000, "R5");
        // R6: flag-only operations, set_flags low
        run_op(32'h0000_0001, 32'hFFFF_FFFF, 3'd0, 8'd0, 4'd8, 1'b0, 4'd14, 4'b0000, "R6");
        run_op(32'h0000_0003, 32'h0000_0005, 3'd0, 8'd0, 4'd7, 1'b0, 4'd14, 4'b0000, "R6");
        run_op(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'd0, 8'd0, 4'd5, 1'b0, 4'd14, 4'b0000, "R6");
        // R7: test-equivalence keeps C and V, other logical ops take shifter carry
        run_op(32'h1234_5678, 32'h1234_5678, 3'd0, 8'd0, 4'd6, 1'b0, 4'd14, 4'b0011, "R7");
        run_op(32'h8000_0000, 32'h0000_0001, 3'd0, 8'd31, 4'd6, 1'b0, 4'd14, 4'b0010, "R7");
        run_op(32'hFFFF_FFFF, 32'h8000_0000, 3'd0, 8'd1, 4'd0, 1'b1, 4'd14, 4'b0001, "R7");
        // R8: no flag update without set_flags
        run_op(32'h7FFF_FFFF, 32'h0000_0001, 3'd0, 8'd0, 4'd4, 1'b0, 4'd14, 4'b1010, "R8");
        run_op(32'h0, 32'h0, 3'd0, 8'd0, 4'd10, 1'b0, 4'd14, 4'b0101, "R8");
        // R11: reserved opcodes
        for (int k = 13; k < 16; k++)
            run_op(32'h1, 32'h2, 3'd0, 8'd0, 4'(k), 1'b1, 4'd14, 4'b1001, "R11");

        // R9: full condition sweep, writing move then flag-setting compare
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                run_op(32'h0, 32'(c * 16 + f + 1), 3'd0, 8'd0, 4'd10, 1'b1,
                       4'(c), 4'(f), "R9");
                run_op(32'(f), 32'(c), 3'd0, 8'd0, 4'd7, 1'b0, 4'(c), 4'(f), "R9");
            end
        end

        @(negedge clk);
        cond = 4'hF;
        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule